// File: doc/BRIEF.md
# Buffered Multi-Frame Serial Transmitter

This block sends bytes on a single serial line. A host writes a byte into a one-word holding register. The byte then moves into an internal shift register at a bit-tick boundary, which frees the holding register so the host can write the next byte at once. A status flag tells the host when the holding register can take another byte, and an interrupt request can be raised at that moment. Three frame shapes are supported: plain asynchronous, asynchronous with an extra address/data marker bit, and clock-synchronous with a shift clock output. In the synchronous shape, bytes follow one another with no gap.

Bit timing comes from outside on a one-cycle `bit_tick` pulse. Each pulse moves the line to the next bit. Ticks must be at least two clock cycles apart. When transmission is switched off in the middle of a frame, the buffer-empty flag sets at once. The block still sends the frame in progress and any byte already held in the holding register, and then it stops. A byte written while transmission is off waits in the holding register until transmission is switched on again.

The host uses three write addresses. Address 0 holds data. Address 1 holds control: bit 0 transmit enable, bit 1 receive enable, bit 2 interrupt enable, bits 4:3 frame mode, bit 5 marker value. Address 2 is the status clear: writing 1 in bit 0 clears the collision flag.

Top module: `sertx_top`

## Requirements
- R1: While reset is low and right after it is released, `ser_out` = 1, `sclk_out` = 1, `tx_empty` = 1, `tx_irq` = 0 and `wr_coll` = 0.
- R2: With mode 0 (and mode 3, which behaves the same), each byte is sent as a 0 start bit, then data bits LSB first, then a 1 stop bit. Each bit lasts from one tick to the next.
- R3: With mode 1, the value of control bit 5 is sent between the last data bit and the stop bit. The value used is the one present when the byte enters the shift register.
- R4: With mode 2, only the data bits are sent, LSB first. The MSB of one byte is followed directly by the LSB of the next when that byte is waiting. Transmission is on only while both control bits 0 and 1 are 1. In modes 0, 1 and 3, bit 0 alone turns transmission on.
- R5: `sclk_out` idles at 1 and goes low only in mode 2. It goes low in the same cycle that a new data bit appears on `ser_out`, and returns to 1 on the next clock.
- R6: A data write when the holding register is free stores the byte and clears `tx_empty`. On a tick where the shifter is idle or is on its last bit, a held byte moves into the shifter if transmission is on, and `tx_empty` sets.
- R7: `tx_irq` equals `tx_empty` AND control bit 2.
- R8: A data write while the holding register is occupied is dropped and sets `wr_coll`. `wr_coll` stays set until a write to address 2 with bit 0 = 1. A write to address 2 with bit 0 = 0 leaves it unchanged.
- R9: A control write that turns transmission off sets `tx_empty` in the same cycle. The frame in progress and a byte already held are still sent in full, and then the line stays idle.
- R10: A byte written while transmission is off stays held (`tx_empty` = 0, line idle) and is sent after transmission is turned on.
- R11: `ser_out` is 1 whenever no frame is in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| bit_tick | input | 1 | One-cycle pulse per serial bit period |
| wr_en | input | 1 | Host write strobe |
| wr_addr | input | 2 | Host write address (0 data, 1 control, 2 status clear) |
| wr_data | input | DATA_W | Host write data |
| tx_empty | output | 1 | Holding register may accept a byte |
| tx_irq | output | 1 | Interrupt request, level |
| wr_coll | output | 1 | Sticky write-collision flag |
| ser_out | output | 1 | Serial data line |
| sclk_out | output | 1 | Shift clock for synchronous mode |

## Verification
The bench builds the block with the default DATA_W of 8 and a tick every four clocks. Frames are therefore 10, 11 or 8 ticks long, so several whole frames, back-to-back synchronous bytes and a disable-while-draining sequence all fit in a short run. Four clocks per tick also leaves room for the one-clock low pulse on the shift clock to be seen between bits.

// File: rtl/sertx_pkg.sv
`timescale 1ns/1ps
// Shared types for the serial transmitter: frame modes, register addresses
// and the control register layout. Assumes a 2-bit host address space.
package sertx_pkg;

    typedef enum logic [1:0] {
        MODE_ASYNC = 2'd0,
        MODE_MARK  = 2'd1,
        MODE_SYNC  = 2'd2,
        MODE_ALT   = 2'd3
    } frame_mode_e;

    localparam logic [1:0] ADDR_DATA = 2'd0;
    localparam logic [1:0] ADDR_CTRL = 2'd1;
    localparam logic [1:0] ADDR_STAT = 2'd2;

    localparam int CTRL_W = 6;

    typedef struct packed {
        logic        mark_val;
        frame_mode_e mode;
        logic        irq_en;
        logic        rx_en;
        logic        tx_en;
    } ctrl_t;

endpackage

// File: rtl/sertx_regs.sv
`timescale 1ns/1ps
// Host-side state: the control register, the one-word holding register and
// the empty / collision flags. A held byte is released to the shifter through
// `go`. Assumes DATA_W >= CTRL_W so the control fields fit in a write word.
module sertx_regs
    import sertx_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [1:0]        wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              take,
    output ctrl_t             ctrl,
    output logic [DATA_W-1:0] hold_data,
    output logic              go,
    output logic              empty,
    output logic              coll,
    output logic              irq
);

    ctrl_t             ctrl_q;
    logic [DATA_W-1:0] hold_q;
    logic              full_q;
    logic              owed_q;
    logic              empty_q;
    logic              coll_q;

    ctrl_t ctrl_new;
    logic  run_now;
    logic  run_new;
    logic  data_wr;
    logic  ctrl_wr;
    logic  stat_wr;
    logic  drop;

    // Decode the write strobe and work out the transmit-enable transitions.
    always_comb begin
        ctrl_new = ctrl_t'(wr_data[CTRL_W-1:0]);
        run_now  = ctrl_q.tx_en & ((ctrl_q.mode != MODE_SYNC) | ctrl_q.rx_en);
        run_new  = ctrl_new.tx_en & ((ctrl_new.mode != MODE_SYNC) | ctrl_new.rx_en);
        data_wr  = wr_en & (wr_addr == ADDR_DATA);
        ctrl_wr  = wr_en & (wr_addr == ADDR_CTRL);
        stat_wr  = wr_en & (wr_addr == ADDR_STAT);
        drop     = ctrl_wr & run_now & ~run_new;
    end

    // Control register.
    always_ff @(posedge clk) begin
        if (!rst_n)       ctrl_q <= '0;
        else if (ctrl_wr) ctrl_q <= ctrl_new;
    end

    // Holding register, its occupancy, the drain obligation and the empty flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hold_q  <= '0;
            full_q  <= 1'b0;
            owed_q  <= 1'b0;
            empty_q <= 1'b1;
        end else begin
            if (take) begin
                full_q  <= 1'b0;
                owed_q  <= 1'b0;
                empty_q <= 1'b1;
            end
            if (data_wr && !full_q) begin
                hold_q  <= wr_data;
                full_q  <= 1'b1;
                empty_q <= 1'b0;
            end
            if (drop) begin
                empty_q <= 1'b1;
                owed_q  <= full_q & ~take;
            end
        end
    end

    // Sticky collision flag, cleared by writing 1 to the status address.
    always_ff @(posedge clk) begin
        if (!rst_n)                        coll_q <= 1'b0;
        else if (data_wr && full_q)        coll_q <= 1'b1;
        else if (stat_wr && wr_data[0])    coll_q <= 1'b0;
    end

    assign ctrl      = ctrl_q;
    assign hold_data = hold_q;
    assign go        = full_q & (run_now | owed_q);
    assign empty     = empty_q;
    assign coll      = coll_q;
    assign irq       = empty_q & ctrl_q.irq_en;

endmodule

// File: rtl/sertx_shifter.sv
`timescale 1ns/1ps
// Frame builder and shift register. On a tick it either moves to the next
// bit or, when idle or on the last bit and `go` is high, loads a new frame.
// Assumes ticks are single-cycle pulses at least two clocks apart.
module sertx_shifter
    import sertx_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  frame_mode_e       mode,
    input  logic              mark_val,
    input  logic [DATA_W-1:0] hold_data,
    input  logic              go,
    output logic              take,
    output logic              ser_out,
    output logic              sclk_out
);

    localparam int FRAME_W = DATA_W + 3;
    localparam int CNT_W   = $clog2(FRAME_W + 1);

    logic [FRAME_W-1:0] shreg_q;
    logic [CNT_W-1:0]   left_q;
    logic               sclk_q;

    logic [FRAME_W-1:0] frame;
    logic [CNT_W-1:0]   frame_len;
    logic               busy;
    logic               last;
    logic               sync_mode;

    // Assemble the next frame, padded with mark bits, and its length.
    always_comb begin
        unique case (mode)
            MODE_SYNC: begin
                frame     = {3'b111, hold_data};
                frame_len = CNT_W'(DATA_W);
            end
            MODE_MARK: begin
                frame     = {1'b1, mark_val, hold_data, 1'b0};
                frame_len = CNT_W'(DATA_W + 3);
            end
            default: begin
                frame     = {2'b11, hold_data, 1'b0};
                frame_len = CNT_W'(DATA_W + 2);
            end
        endcase
    end

    assign busy      = (left_q != '0);
    assign last      = (left_q == CNT_W'(1));
    assign sync_mode = (mode == MODE_SYNC);
    assign take      = tick & go & (~busy | last);

    // Load a frame or advance by one bit on each tick.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shreg_q <= '1;
            left_q  <= '0;
        end else if (take) begin
            shreg_q <= frame;
            left_q  <= frame_len;
        end else if (tick && busy) begin
            shreg_q <= {1'b1, shreg_q[FRAME_W-1:1]};
            left_q  <= left_q - CNT_W'(1);
        end
    end

    // Drop the shift clock for one cycle whenever a new synchronous bit starts.
    always_ff @(posedge clk) begin
        if (!rst_n) sclk_q <= 1'b1;
        else        sclk_q <= ~(sync_mode & tick & (take | (busy & ~last)));
    end

    assign ser_out  = busy ? shreg_q[0] : 1'b1;
    assign sclk_out = sclk_q;

endmodule

// File: rtl/sertx_top.sv
`timescale 1ns/1ps
// Serial transmitter top: joins the host register block to the shifter.
// Assumes an external bit-tick source and DATA_W >= 6.
module sertx_top
    import sertx_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bit_tick,
    input  logic              wr_en,
    input  logic [1:0]        wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    output logic              tx_empty,
    output logic              tx_irq,
    output logic              wr_coll,
    output logic              ser_out,
    output logic              sclk_out
);

    ctrl_t             ctrl_s;
    logic [DATA_W-1:0] hold_s;
    logic              go_s;
    logic              take_s;

    sertx_regs #(.DATA_W(DATA_W)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data),
        .take      (take_s),
        .ctrl      (ctrl_s),
        .hold_data (hold_s),
        .go        (go_s),
        .empty     (tx_empty),
        .coll      (wr_coll),
        .irq       (tx_irq)
    );

    sertx_shifter #(.DATA_W(DATA_W)) u_shift (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick      (bit_tick),
        .mode      (ctrl_s.mode),
        .mark_val  (ctrl_s.mark_val),
        .hold_data (hold_s),
        .go        (go_s),
        .take      (take_s),
        .ser_out   (ser_out),
        .sclk_out  (sclk_out)
    );

endmodule

// File: rtl/sertx_chk.sv
`timescale 1ns/1ps
// Property checker for the serial transmitter, attached by bind.
// Assumes the same reset and clock as the block it watches.
module sertx_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       bit_tick,
    input logic       wr_en,
    input logic [1:0] wr_addr,
    input logic       wr_bit0,
    input logic       sync_mode,
    input logic       tx_empty,
    input logic       tx_irq,
    input logic       wr_coll,
    input logic       sclk_out
);

    AST_SCLK_FALL_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sclk_out) |-> $past(bit_tick)); // R5

    AST_SCLK_SYNC_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        !sclk_out |-> $past(sync_mode)); // R5

    AST_IRQ_NEEDS_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        tx_irq |-> tx_empty); // R7

    AST_COLL_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_coll && !(wr_en && wr_addr == 2'd2 && wr_bit0)) |=> wr_coll); // R8

    AST_COLL_FROM_DATA_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wr_coll) |-> $past(wr_en && wr_addr == 2'd0)); // R8

    AST_EMPTY_FALL_ON_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(tx_empty) |-> $past(wr_en && wr_addr == 2'd0)); // R6

    AST_EMPTY_RISE_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tx_empty) |-> ($past(bit_tick) || $past(wr_en && wr_addr == 2'd1))); // R9

endmodule

bind sertx_top sertx_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bit_tick  (bit_tick),
    .wr_en     (wr_en),
    .wr_addr   (wr_addr),
    .wr_bit0   (wr_data[0]),
    .sync_mode (ctrl_s.mode == sertx_pkg::MODE_SYNC),
    .tx_empty  (tx_empty),
    .tx_irq    (tx_irq),
    .wr_coll   (wr_coll),
    .sclk_out  (sclk_out)
);

// File: tb/sertx_top_tb_top.sv
`timescale 1ns/1ps
// Bench: behavioural reference model updated every clock, compared on every clock.
module sertx_top_tb_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bit_tick = 1'b0;
    logic       wr_en = 1'b0;
    logic [1:0] wr_addr = 2'd0;
    logic [7:0] wr_data = 8'd0;
    logic       tx_empty, tx_irq, wr_coll, ser_out, sclk_out;

    int    n_chk = 0;
    int    n_err = 0;
    bit    cmp_on = 1'b0;
    bit    done = 1'b0;
    string ph = "R2";

    // reference model state
    bit       m_full, m_owed, m_empty, m_coll, m_sclk;
    bit [7:0] m_data;
    bit [5:0] m_ctrl;
    bit       m_bits[$];
    int       tick_cnt = 0;

    always #2 clk = ~clk;

    sertx_top #(.DATA_W(8)) dut_i (
        .clk(clk), .rst_n(rst_n), .bit_tick(bit_tick), .wr_en(wr_en),
        .wr_addr(wr_addr), .wr_data(wr_data), .tx_empty(tx_empty),
        .tx_irq(tx_irq), .wr_coll(wr_coll), .ser_out(ser_out), .sclk_out(sclk_out)
    );

    // Tick every fourth clock.
    always @(negedge clk) begin
        tick_cnt = (tick_cnt + 1) % 4;
        bit_tick = (tick_cnt == 3);
    end

    // Reference model, advanced at each rising edge from the driven inputs.
    always @(posedge clk) begin
        if (!rst_n) begin
            m_full = 0; m_owed = 0; m_empty = 1; m_coll = 0; m_sclk = 1;
            m_data = 0; m_ctrl = 0; m_bits.delete();
        end else begin
            bit sync, en, go, take, full_pre, nen;
            sync = (m_ctrl[4:3] == 2'd2);
            en = m_ctrl[0] && (!sync || m_ctrl[1]);
            go = m_full && (en || m_owed);
            take = bit_tick && go && (m_bits.size() <= 1);
            full_pre = m_full;
            m_sclk = 1;
            if (bit_tick) begin
                if (m_bits.size() > 1) begin
                    void'(m_bits.pop_front());
                    if (sync) m_sclk = 0;
                end else if (take) begin
                    m_bits.delete();
                    if (!sync) m_bits.push_back(1'b0);
                    for (int i = 0; i < 8; i++) m_bits.push_back(m_data[i]);
                    if (m_ctrl[4:3] == 2'd1) m_bits.push_back(m_ctrl[5]);
                    if (!sync) m_bits.push_back(1'b1);
                    m_full = 0; m_empty = 1; m_owed = 0;
                    if (sync) m_sclk = 0;
                end else if (m_bits.size() == 1) begin
                    void'(m_bits.pop_front());
                end
            end
            if (wr_en && wr_addr == 2'd0) begin
                if (!full_pre) begin m_data = wr_data; m_full = 1; m_empty = 0; end
                else m_coll = 1;
            end
            if (wr_en && wr_addr == 2'd1) begin
                nen = wr_data[0] && (wr_data[4:3] != 2'd2 || wr_data[1]);
                if (en && !nen) begin m_empty = 1; m_owed = full_pre && !take; end
                m_ctrl = wr_data[5:0];
            end
            if (wr_en && wr_addr == 2'd2 && wr_data[0]) m_coll = 0;
        end
    end

    task automatic chk(string tag, logic act, logic exp, string what);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s %s: actual %b expected %b at %0t", tag, what, act, exp, $time);
        end
    endtask

    // Compare every output against the model on each falling edge.
    always @(negedge clk) begin
        if (cmp_on && !done) begin
            chk((m_bits.size() > 0) ? ph : "R11", ser_out,
                (m_bits.size() > 0) ? m_bits[0] : 1'b1, "ser_out");
            chk("R5", sclk_out, m_sclk, "sclk_out");
            chk("R6", tx_empty, m_empty, "tx_empty");
            chk("R7", tx_irq, m_empty && m_ctrl[2], "tx_irq");
            chk("R8", wr_coll, m_coll, "wr_coll");
        end
    end

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 0;
    endtask

    task automatic wait_clks(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wait_empty();
        while (tx_empty !== 1'b1) @(negedge clk);
    endtask

    task automatic finish_run();
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    endtask

    // Watchdog: a hung run counts as a failure.
    initial begin
        #(4 * 150000);
        if (!done) begin
            n_chk++; n_err++;
            $display("FAIL watchdog: actual timeout expected completion");
            finish_run();
        end
    end

    initial begin
        wait_clks(3);
        chk("R1", ser_out, 1'b1, "ser_out in reset");
        chk("R1", sclk_out, 1'b1, "sclk_out in reset");
        @(negedge clk) rst_n = 1;
        @(negedge clk);
        chk("R1", tx_empty, 1'b1, "tx_empty after reset");
        chk("R1", tx_irq, 1'b0, "tx_irq after reset");
        chk("R1", wr_coll, 1'b0, "wr_coll after reset");
        cmp_on = 1;

        // R2: plain asynchronous, plus collision and its clearing (R8)
        ph = "R2";
        wr(2'd1, 8'b000101);
        wr(2'd0, 8'hA5);
        wait_empty();
        wr(2'd0, 8'h3C);
        wr(2'd0, 8'h77);
        wr(2'd2, 8'h00);
        chk("R8", wr_coll, 1'b1, "coll kept by write of 0");
        wr(2'd2, 8'h01);
        chk("R8", wr_coll, 1'b0, "coll cleared by write of 1");
        wait_clks(100);
        wr(2'd1, 8'b011001);
        wr(2'd0, 8'h0F);
        wait_clks(60);

        // R3: marker bit 1 then 0
        ph = "R3";
        wr(2'd1, 8'b101101);
        wr(2'd0, 8'h81);
        wait_empty();
        wr(2'd0, 8'h42);
        wait_clks(10);
        wr(2'd1, 8'b001101);
        wait_empty();
        wr(2'd0, 8'hE7);
        wait_clks(120);

        // R4: synchronous back-to-back, then rx_en gating
        ph = "R4";
        wr(2'd1, 8'b010111);
        for (int k = 0; k < 3; k++) begin
            wait_empty();
            wr(2'd0, 8'hC3 ^ 8'(k * 37));
        end
        wait_clks(80);
        wr(2'd1, 8'b010101);
        wr(2'd0, 8'h5E);
        wait_clks(40);
        chk("R4", tx_empty, 1'b0, "held while rx_en low");
        chk("R4", ser_out, 1'b1, "idle while rx_en low");
        wr(2'd1, 8'b010111);
        wait_clks(12);
        wr(2'd0, 8'h96);
        wait_clks(4);
        wr(2'd1, 8'b010101);
        chk("R9", tx_empty, 1'b1, "sync drop sets empty");
        wait_clks(80);

        // R9: asynchronous disable while a byte is held
        ph = "R9";
        wr(2'd1, 8'b000101);
        wr(2'd0, 8'h5A);
        wait_empty();
        wr(2'd0, 8'hE1);
        wait_clks(8);
        chk("R9", tx_empty, 1'b0, "byte held before drop");
        wr(2'd1, 8'b000100);
        chk("R9", tx_empty, 1'b1, "drop sets empty");
        chk("R9", tx_irq, 1'b1, "drop raises irq");
        wait_clks(100);
        chk("R9", ser_out, 1'b1, "idle after drain");

        // R10: write while off, then enable
        ph = "R10";
        wr(2'd0, 8'h99);
        wait_clks(60);
        chk("R10", tx_empty, 1'b0, "held while off");
        chk("R10", ser_out, 1'b1, "not sent while off");
        wr(2'd1, 8'b000101);
        wait_clks(60);
        chk("R10", tx_empty, 1'b1, "sent after enable");
        wait_clks(4);

        finish_run();
    end

endmodule